// File: doc/BRIEF.md
# I2C Banked Register Write Target

This block is an I2C target that takes write transfers into a 40-bit I/O expander register map. The map has four writable groups: output port, polarity inversion, direction configuration and interrupt mask. Each group holds five 8-bit banks. SCL and SDA are sampled with the system clock through a two-stage synchroniser. The block drives SDA only through an open-drain pull-low enable.

In a transfer, the target address comes first, then a command byte, then any number of data bytes. The command byte gives the starting register and says whether later bytes advance through the banks of that group. Output-port data reaches the port in one of two ways, chosen by a mode input:
- held in a staging copy and applied all together when the STOP condition arrives, or
- applied bank by bank, at the acknowledge of each byte.

The port is driven only when the output-enable input matches its programmable polarity.

Top module: `bankreg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `devAddr` and its bit 0 (read/write) is 0. Otherwise it never pulls SDA low until the next START or STOP, and the rest of the transfer changes no register.
- R2: In an addressed write, the command byte and every data byte are acknowledged: `sdaOe` is high while SCL is high during the ninth clock.
- R3: The command byte has bit 7 as the advance flag and bits 5:3 as the group: 1 = output port, 2 = polarity, 3 = configuration, 4 = mask. Bits 2:0 are the bank (0..4, bank n occupying bits 8n+7:8n of the group's 40-bit vector). A bank of 5..7 or a group outside 1..4 makes the data bytes write nothing.
- R4: With the advance flag set, each data byte goes to the next bank of the same group, going from bank 4 to bank 0. After five bytes the writes return to the first addressed bank and overwrite it.
- R5: With the advance flag clear, every data byte of the transfer goes to the same bank.
- R6: With `commitOnAck` = 0, output-port writes leave `portOut` unchanged during the transfer. They appear together three clock cycles after SCL-high SDA rises (STOP).
- R7: With `commitOnAck` = 1, each output-port byte appears on the port three clock cycles after SCL rises for the ninth bit of that byte.
- R8: Polarity, configuration and mask bytes are written at the ninth-clock SCL rise of their byte in both modes, with the same three-cycle latency.
- R9: `portEn` is 1 exactly when `oeIn` equals `oePol`. `portOut` carries the output-port register when `portEn` is 1 and is all zeros otherwise.
- R10: A repeated START discards staged output-port data that has not been committed. A later STOP commits only data written after that START.
- R11: After reset all four register groups are zero and `sdaOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sdaOe | output | 1 | 1 pulls SDA low |
| devAddr | input | 7 | Target address |
| commitOnAck | input | 1 | 1 = output bytes commit at each acknowledge, 0 = at STOP |
| oeIn | input | 1 | Output-enable input |
| oePol | input | 1 | Level of `oeIn` that enables the port |
| portEn | output | 1 | Port drive enable |
| portOut | output | 40 | Output-port value while enabled |
| polBits | output | 40 | Polarity-inversion register group |
| cfgBits | output | 40 | Configuration register group |
| maskBits | output | 40 | Interrupt-mask register group |

## Verification
The bench targets the advance wrap. A run starting at bank 2 with six bytes must land its sixth byte back on bank 2. A design that wraps at bank 7, or that resets to bank 0, puts data in the wrong slice. In STOP mode the port must not move during the transfer. A repeated START must throw away the staged bytes: a design that commits early, or that keeps stale staging, shows wrong port bits in the every-clock comparison. The bench also covers a wrong address, a read bit, invalid banks and groups, and all four enable/polarity combinations. These catch a target that acknowledges when it should not, writes through a bad pointer, or inverts the enable.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int BANK_W = 8;
  localparam int PTR_BANK_W = 3;

  typedef enum logic [2:0] {
    GRP_OUT = 3'd1,
    GRP_POL = 3'd2,
    GRP_CFG = 3'd3,
    GRP_MSK = 3'd4
  } grp_e;

  typedef struct packed {
    logic              xferStart;
    logic              xferStop;
    logic              cmdWr;
    logic              dataWr;
    logic [BANK_W-1:0] rxByte;
  } strobe_t;
endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] devAddr,
  output logic       sdaOe,
  output strobe_t    strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK, ST_SKIP} state_e;

  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic startSeen, stopSeen, sclRise, sclFall;
  state_e state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic [1:0] byteIdx;
  logic addrHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow    = sclPipe[SYNC_STAGES-1];
  assign sclOld    = sclPipe[SYNC_STAGES];
  assign sdaNow    = sdaPipe[SYNC_STAGES-1];
  assign sdaOld    = sdaPipe[SYNC_STAGES];
  assign startSeen = sclNow && sclOld && sdaOld && !sdaNow;
  assign stopSeen  = sclNow && sclOld && !sdaOld && sdaNow;
  assign sclRise   = sclNow && !sclOld;
  assign sclFall   = !sclNow && sclOld;
  assign addrHit   = (shiftReg[7:1] == devAddr) && !shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      byteIdx  <= '0;
      sdaOe    <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_RECV;
      bitCnt  <= '0;
      byteIdx <= '0;
      sdaOe   <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise) begin
            shiftReg <= {shiftReg[6:0], sdaNow};
            bitCnt   <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (byteIdx != 2'd0 || addrHit) begin
              sdaOe <= 1'b1;
              state <= ST_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            state  <= ST_RECV;
            bitCnt <= '0;
            if (byteIdx != 2'd2) byteIdx <= byteIdx + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.xferStart = startSeen;
    strb.xferStop  = stopSeen;
    strb.cmdWr     = (state == ST_ACK) && sclRise && (byteIdx == 2'd1);
    strb.dataWr    = (state == ST_ACK) && sclRise && (byteIdx == 2'd2);
    strb.rxByte    = shiftReg;
  end

  assert_sda_moves_on_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> ($past(sclFall) || $past(startSeen) || $past(stopSeen)));

  assert_release_after_stop_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  assert_silent_when_skipped_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe);
endmodule

// File: rtl/bankreg_regs.sv
module bankreg_regs
  import bankreg_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int WIDTH = NUM_BANKS * BANK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             commitOnAck,
  output logic [WIDTH-1:0] outReg,
  output logic [WIDTH-1:0] polReg,
  output logic [WIDTH-1:0] cfgReg,
  output logic [WIDTH-1:0] mskReg
);
  localparam logic [PTR_BANK_W-1:0] LAST_BANK = PTR_BANK_W'(NUM_BANKS - 1);

  logic [2:0] ptrGrp;
  logic [PTR_BANK_W-1:0] ptrBank;
  logic autoInc;
  logic dirty;
  logic [NUM_BANKS-1:0] bankSel;
  logic anyBank;
  logic outHit;
  logic unusedCmdBit;

  assign unusedCmdBit = strb.rxByte[6];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrGrp  <= '0;
      ptrBank <= '0;
      autoInc <= 1'b0;
    end else if (strb.cmdWr) begin
      autoInc <= strb.rxByte[7];
      ptrGrp  <= strb.rxByte[5:3];
      ptrBank <= strb.rxByte[2:0];
    end else if (strb.dataWr && autoInc && anyBank) begin
      ptrBank <= (ptrBank == LAST_BANK) ? '0 : ptrBank + 1'b1;
    end
  end

  assign anyBank = |bankSel;
  assign outHit  = strb.dataWr && anyBank && (ptrGrp == GRP_OUT);

  always_ff @(posedge clk) begin
    if (!rstN) dirty <= 1'b0;
    else if (strb.xferStart || strb.xferStop || strb.cmdWr) dirty <= 1'b0;
    else if (outHit && !commitOnAck) dirty <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    logic [BANK_W-1:0] outB, stageB, polB, cfgB, mskB;
    logic hit;

    assign bankSel[b] = (ptrBank == PTR_BANK_W'(b));
    assign hit = strb.dataWr && bankSel[b];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outB   <= '0;
        stageB <= '0;
        polB   <= '0;
        cfgB   <= '0;
        mskB   <= '0;
      end else begin
        if (strb.cmdWr) begin
          stageB <= outB;
        end else if (hit && ptrGrp == GRP_OUT) begin
          stageB <= strb.rxByte;
          if (commitOnAck) outB <= strb.rxByte;
        end
        if (strb.xferStop && dirty) outB <= stageB;
        if (hit && ptrGrp == GRP_POL) polB <= strb.rxByte;
        if (hit && ptrGrp == GRP_CFG) cfgB <= strb.rxByte;
        if (hit && ptrGrp == GRP_MSK) mskB <= strb.rxByte;
      end
    end

    assign outReg[LO +: BANK_W] = outB;
    assign polReg[LO +: BANK_W] = polB;
    assign cfgReg[LO +: BANK_W] = cfgB;
    assign mskReg[LO +: BANK_W] = mskB;
  end

  assert_out_change_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outReg) |-> ($past(strb.dataWr) || $past(strb.xferStop)));

  assert_stopmode_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && !commitOnAck) |=> $stable(outReg));

  assert_cfg_change_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgReg) |-> $past(strb.dataWr));
endmodule

// File: rtl/bankreg_i2c_target.sv
module bankreg_i2c_target
  import bankreg_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int WIDTH = NUM_BANKS * BANK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [6:0]       devAddr,
  input  logic             commitOnAck,
  input  logic             oeIn,
  input  logic             oePol,
  output logic             portEn,
  output logic [WIDTH-1:0] portOut,
  output logic [WIDTH-1:0] polBits,
  output logic [WIDTH-1:0] cfgBits,
  output logic [WIDTH-1:0] maskBits
);
  strobe_t strb;
  logic [WIDTH-1:0] outReg;

  bankreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devAddr(devAddr), .sdaOe(sdaOe), .strb(strb)
  );

  bankreg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .commitOnAck(commitOnAck),
    .outReg(outReg), .polReg(polBits), .cfgReg(cfgBits), .mskReg(maskBits)
  );

  assign portEn  = (oeIn == oePol);
  assign portOut = portEn ? outReg : '0;
endmodule

// File: tb/sim_bankreg_i2c_target.sv
`timescale 1ns/1ps
module sim_bankreg_i2c_target;
  localparam int W = 40;
  localparam int Q = 4;
  localparam int H = 8;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msScl = 1'b1, msSda = 1'b1;
  logic commitOnAck = 1'b0, oeIn = 1'b0, oePol = 1'b0;
  logic sdaOe, portEn;
  logic [W-1:0] portOut, polBits, cfgBits, maskBits;
  logic sdaLine;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;
  assign sdaLine = msSda & ~sdaOe;

  bankreg_i2c_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(msScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .devAddr(DEV), .commitOnAck(commitOnAck), .oeIn(oeIn), .oePol(oePol),
    .portEn(portEn), .portOut(portOut), .polBits(polBits),
    .cfgBits(cfgBits), .maskBits(maskBits)
  );

  // behavioural reference state
  logic [W-1:0] mOut = '0, mPol = '0, mCfg = '0, mMsk = '0, mStage = '0;
  bit mDirty = 0, mActive = 0, mAi = 0;
  int mIdx = 0, mGrp = 0, mBank = 0;
  logic [W-1:0] dOut[3], dPol[3], dCfg[3], dMsk[3];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        dOut[i] <= '0; dPol[i] <= '0; dCfg[i] <= '0; dMsk[i] <= '0;
      end
    end else begin
      dOut[0] <= mOut; dPol[0] <= mPol; dCfg[0] <= mCfg; dMsk[0] <= mMsk;
      for (int i = 1; i < 3; i++) begin
        dOut[i] <= dOut[i-1]; dPol[i] <= dPol[i-1];
        dCfg[i] <= dCfg[i-1]; dMsk[i] <= dMsk[i-1];
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the delayed model
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      chk("R6/R7/R9 port", portOut, (oeIn == oePol) ? dOut[2] : '0);
      chk("R8 polarity", polBits, dPol[2]);
      chk("R8 config", cfgBits, dCfg[2]);
      chk("R8 mask", maskBits, dMsk[2]);
      chk("R9 enable", {39'd0, portEn}, {39'd0, oeIn == oePol});
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelStart();
    mIdx = 0; mActive = 0; mDirty = 0;
  endtask

  task automatic modelStop();
    if (mDirty) mOut = mStage;
    mDirty = 0; mActive = 0;
  endtask

  task automatic modelByte(input logic [7:0] b);
    if (mIdx == 0) begin
      mActive = (b[7:1] == DEV) && !b[0];
    end else if (mActive && mIdx == 1) begin
      mAi = b[7]; mGrp = int'(b[5:3]); mBank = int'(b[2:0]);
      mStage = mOut; mDirty = 0;
    end else if (mActive && mBank < 5) begin
      case (mGrp)
        1: begin
          mStage[mBank*8 +: 8] = b;
          if (commitOnAck) mOut[mBank*8 +: 8] = b;
          else mDirty = 1;
        end
        2: mPol[mBank*8 +: 8] = b;
        3: mCfg[mBank*8 +: 8] = b;
        4: mMsk[mBank*8 +: 8] = b;
        default: ;
      endcase
      if (mAi) mBank = (mBank + 1) % 5;
    end
    if (mIdx < 2) mIdx++;
  endtask

  task automatic i2cStart();
    msSda = 1'b1; wt(Q); msScl = 1'b1; wt(H);
    msSda = 1'b0; modelStart(); wt(H);
    msScl = 1'b0;
  endtask

  task automatic i2cStop();
    wt(Q); msSda = 1'b0; wt(Q); msScl = 1'b1; wt(H);
    msSda = 1'b1; modelStop(); wt(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    bit expAck;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); msSda = b[i]; wt(Q); msScl = 1'b1; wt(H); msScl = 1'b0;
    end
    wt(Q); msSda = 1'b1; wt(Q);
    msScl = 1'b1;
    expAck = (mIdx == 0) ? ((b[7:1] == DEV) && !b[0]) : mActive;
    modelByte(b);
    wt(H / 2);
    chk(tag, {39'd0, !sdaLine}, {39'd0, expAck});
    wt(H / 2);
    msScl = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] data[$]);
    i2cStart();
    sendByte({DEV, 1'b0}, "R1 address ack");
    sendByte(cmd, "R2 command ack");
    foreach (data[i]) sendByte(data[i], "R2 data ack");
    i2cStop();
    wt(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    wt(5);
    chk("R11 sdaOe reset", {39'd0, sdaOe}, '0);
    chk("R11 port reset", portOut, '0);
    rstN = 1'b1;
    wt(5);
    chk("R11 cfg reset", cfgBits, '0);

    // R6 + R4: five output banks in STOP mode
    commitOnAck = 1'b0;
    q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    xfer(8'h88, q);
    chk("R6 stop commit", portOut, 40'h5544332211);

    // R7: single bank, ack mode, no advance
    commitOnAck = 1'b1;
    q = '{8'hA7};
    xfer(8'h0B, q);
    chk("R7 ack commit bank3", portOut, 40'h55A7332211);
    q = '{8'h01, 8'h02, 8'h03};
    xfer(8'h8A, q);
    chk("R7 ack commit banks2-4", portOut, 40'h0302012211);

    // R4 wrap: polarity from bank 2, six bytes
    q = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6};
    xfer(8'h92, q);
    chk("R4 wrap polarity", polBits, 40'hC3C2C6C5C4);

    // R5: no advance, configuration bank 1
    commitOnAck = 1'b0;
    q = '{8'h5A, 8'h6B, 8'h7C};
    xfer(8'h19, q);
    chk("R5 same bank", cfgBits, 40'h0000007C00);

    // R8: mask bank 0 in STOP mode, written at ack
    q = '{8'hE0, 8'hE1};
    xfer(8'hA0, q);
    chk("R8 mask write", maskBits, 40'h000000E1E0);

    // R3: invalid bank and invalid group are ignored
    q = '{8'hFF, 8'hFF};
    xfer(8'h0E, q);
    xfer(8'h02, q);
    xfer(8'h2C, q);
    chk("R3 invalid port", portOut, 40'h0302012211);
    chk("R3 invalid cfg", cfgBits, 40'h0000007C00);

    // R1: wrong address and read bit
    i2cStart();
    sendByte({DEV ^ 7'h01, 1'b0}, "R1 mismatch no ack");
    sendByte(8'h88, "R1 ignored byte");
    sendByte(8'h99, "R1 ignored byte");
    i2cStop();
    i2cStart();
    sendByte({DEV, 1'b1}, "R1 read bit no ack");
    i2cStop();
    wt(6);
    chk("R1 port untouched", portOut, 40'h0302012211);

    // R10: repeated START discards staged data
    i2cStart();
    sendByte({DEV, 1'b0}, "R10 address");
    sendByte(8'h88, "R10 command");
    sendByte(8'hAA, "R10 data");
    sendByte(8'hBB, "R10 data");
    wt(Q); msSda = 1'b1; wt(Q); msScl = 1'b1; wt(H);
    msSda = 1'b0; modelStart(); wt(H); msScl = 1'b0;
    sendByte({DEV, 1'b0}, "R10 address again");
    sendByte(8'h0C, "R10 command again");
    sendByte(8'h4D, "R10 data again");
    i2cStop();
    wt(6);
    chk("R10 restart discard", portOut, 40'h4D02012211);

    // R9: enable polarity combinations
    oeIn = 1'b1; wt(2);
    chk("R9 oe high pol0", portOut, '0);
    oePol = 1'b1; wt(2);
    chk("R9 oe high pol1", portOut, 40'h4D02012211);
    oeIn = 1'b0; wt(2);
    chk("R9 oe low pol1", portOut, '0);
    oePol = 1'b0; wt(2);
    chk("R9 oe low pol0", portOut, 40'h4D02012211);

    wt(10);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule